// File: doc/BRIEF.md
# UART Interrupt Source Identification

This block sits beside the receive and transmit FIFOs of a 16550-style UART. It turns the current state of those FIFOs and of the other interrupt sources into three things: the identification code that software reads, a single interrupt request line, and the data-ready status bit. The FIFOs report their occupancy as counts. The receiver reports a line-error level and a character-timeout level. The CPU interface reports single-cycle strobes for reading the identification register, writing the holding register and reading the receive buffer.

The sources are ranked as follows: line status first, then receive data or character timeout, then transmit-holding-empty, then modem status. Each source is gated by its own enable bit. With every enable cleared, the UART runs in polled mode: no request is raised, and software reads the status register instead. When the transmit FIFO drains, the empty event can be held back. It is held for a programmable number of bit periods if the FIFO never held two bytes at once since the previous empty event. After the FIFO-enable bit changes, the next transmit interrupt is not held back.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `iir` reads 01h, `irq` is 0 and `data_ready` is 0. Reset arms no transmit-empty interrupt.
- R2: With `fifo_en`=1, receive-data-available (code 4h) is pending while `rx_count` >= `rx_trigger` and `rx_count` is non-zero. It stops in the same cycle that the count drops below the trigger. With `fifo_en`=0 it is pending whenever `rx_count` is non-zero.
- R3: `iir[3:0]` reports the highest enabled pending source: line status 6h, then receive data 4h, then timeout Ch, then transmit empty 2h, then modem 0h. It reads 1h when nothing is pending. `iir[7:6]` both copy `fifo_en`, and `iir[5:4]` read 0.
- R4: Character timeout (code Ch) is reported only when `fifo_en`=1. It uses the receive-data enable. It ranks below a receive-data-available condition that is present in the same cycle.
- R5: Enable bits are `ier[0]` receive data and timeout, `ier[1]` transmit empty, `ier[2]` line status and `ier[3]` modem. `irq` is 1 exactly when some enabled source is pending. With `ier`=0, `iir` reads 1h and `irq` is 0 (polled mode).
- R6: A transmit-empty event sets a pending flag that shows in `iir` one cycle after the qualifying edge. The flag clears on `thr_wr`, or on `iir_rd` in a cycle where `iir[3:0]` is 2h.
- R7: An `iir_rd` in a cycle where another code is reported leaves a pending transmit-empty interrupt in place.
- R8: With `fifo_en`=1, suppose `tx_count` reaches 0 and the FIFO has not held two or more bytes since the last empty event. The event is then held until `char_bits` pulses of `bit_tick` have arrived. It is cancelled if the FIFO becomes non-empty before that.
- R9: If `tx_count` reached 2 or more since the last empty event, the empty event is taken one cycle after `tx_count` reaches 0. This also applies in every case where `fifo_en`=0.
- R10: A change of `fifo_en` while `tx_count` is 0 raises transmit-empty one cycle later. A change while `tx_count` is non-zero makes the next empty event immediate.
- R11: `data_ready` rises one cycle after `rx_push`. It falls one cycle after `rx_count` is 0 without a push, or after `rbr_rd` while `rx_count` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO enable bit from the FIFO control register |
| ier | input | 4 | Interrupt enable bits (modem, line, transmit, receive) |
| rx_count | input | CW | Receive FIFO occupancy |
| rx_trigger | input | CW | Programmed receive trigger level |
| rx_push | input | 1 | A character entered the receive FIFO |
| line_err | input | 1 | Receiver line-status error level |
| char_timeout | input | 1 | Character-timeout level from the timer block |
| modem_stat | input | 1 | Modem status change level |
| tx_count | input | CW | Transmit FIFO occupancy |
| bit_tick | input | 1 | One pulse per transmit bit period |
| char_bits | input | BW | Bit periods of a character less the last stop bit |
| iir_rd | input | 1 | CPU read of the identification register |
| thr_wr | input | 1 | CPU write of the transmit holding register |
| rbr_rd | input | 1 | CPU read of the receive buffer |
| iir | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |
| data_ready | output | 1 | Line status data-ready bit |

## Verification
The receive, timeout, line and modem sources decide `iir` and `irq` combinationally, so their effect is due in the same cycle as the stimulus. The transmit-empty flag and `data_ready` are registered and are due one clock edge after the stimulus. A held-back empty event is due on the edge of the last counted `bit_tick`. Every input change is applied one nanosecond after a rising edge. All outputs are sampled one nanosecond after the following rising edge. At that point the combinational results have settled on the held inputs, and the registered results reflect exactly one edge. The delay tests also sample before the final tick, so an early release is visible.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IER_W = 4;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_THRE    = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_e;

    // pending interrupt sources
    typedef struct packed {
        logic modem;
        logic line;
        logic thre;
        logic timeout;
        logic rxdata;
    } src_t;

    // enable bits in register bit order 3..0
    typedef struct packed {
        logic modem;
        logic line;
        logic thre;
        logic rxdata;
    } ier_t;

    function automatic iid_e pick_source(src_t s, ier_t e);
        iid_e code;
        if (e.line && s.line)            code = IID_LINE;
        else if (e.rxdata && s.rxdata)   code = IID_RXDATA;
        else if (e.rxdata && s.timeout)  code = IID_TIMEOUT;
        else if (e.thre && s.thre)       code = IID_THRE;
        else if (e.modem && s.modem)     code = IID_MODEM;
        else                             code = IID_NONE;
        return code;
    endfunction

    function automatic logic [IER_W-1:0] group_pending(src_t s);
        return {s.modem, s.line, s.thre, s.rxdata | s.timeout};
    endfunction

endpackage

// File: rtl/uart_irq_rx_src.sv
module uart_irq_rx_src #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_trigger,
    input  logic          rx_push,
    input  logic          rbr_rd,
    input  logic          char_timeout,
    output logic          rxdata_pend,
    output logic          timeout_pend,
    output logic          data_ready
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic rx_empty;
    logic last_taken;
    logic dr_q;

    always_comb begin
        rx_empty   = (rx_count == '0);
        last_taken = rbr_rd && (rx_count == ONE);
        if (fifo_en)
            rxdata_pend = !rx_empty && (rx_count >= rx_trigger);
        else
            rxdata_pend = !rx_empty;
        timeout_pend = fifo_en && char_timeout;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dr_q <= 1'b0;
        else if (rx_push)
            dr_q <= 1'b1;
        else if (rx_empty || last_taken)
            dr_q <= 1'b0;
    end

    assign data_ready = dr_q;

endmodule

// File: rtl/uart_irq_thre_ctl.sv
module uart_irq_thre_ctl #(
    parameter int CW = 5,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic [CW-1:0] tx_count,
    input  logic          bit_tick,
    input  logic [BW-1:0] char_bits,
    input  logic          thr_wr,
    input  logic          thre_ack,
    output logic          thre_pend
);
    localparam logic [CW-1:0] TWO    = CW'(2);
    localparam logic [BW-1:0] CNT_ONE = BW'(1);

    logic          tx_empty;
    logic          empty_q;
    logic          fen_q;
    logic          two_seen;
    logic          bypass;
    logic          dly_on;
    logic [BW-1:0] dly_cnt;
    logic          pend_q;

    logic empty_rise;
    logic fen_change;
    logic quick;
    logic dly_done;
    logic fire;
    logic start_dly;

    always_comb begin
        tx_empty   = (tx_count == '0);
        empty_rise = tx_empty && !empty_q;
        fen_change = fifo_en ^ fen_q;
        quick      = !fifo_en || two_seen || bypass || (char_bits == '0);
        dly_done   = dly_on && tx_empty && bit_tick && (dly_cnt == CNT_ONE);
        fire       = (fen_change && tx_empty)
                   || (empty_rise && quick)
                   || dly_done;
        start_dly  = empty_rise && !quick && !fen_change;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_q  <= 1'b1;
            fen_q    <= 1'b0;
            two_seen <= 1'b0;
            bypass   <= 1'b0;
            dly_on   <= 1'b0;
            dly_cnt  <= '0;
            pend_q   <= 1'b0;
        end else begin
            empty_q <= tx_empty;
            fen_q   <= fifo_en;

            if (tx_count >= TWO)
                two_seen <= 1'b1;
            else if (fire)
                two_seen <= 1'b0;

            if (fen_change && !tx_empty)
                bypass <= 1'b1;
            else if (empty_rise)
                bypass <= 1'b0;

            if (start_dly) begin
                dly_on  <= 1'b1;
                dly_cnt <= char_bits;
            end else if (dly_on && (!tx_empty || fire)) begin
                dly_on  <= 1'b0;
            end else if (dly_on && bit_tick) begin
                dly_cnt <= dly_cnt - CNT_ONE;
            end

            if (thr_wr || thre_ack)
                pend_q <= 1'b0;
            else if (fire)
                pend_q <= 1'b1;
        end
    end

    assign thre_pend = pend_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  src_t        src,
    input  ier_t        en,
    input  logic        fifo_en,
    output logic [7:0]  iir,
    output logic        irq
);
    logic [IER_W-1:0] grp;
    logic [IER_W-1:0] en_vec;
    logic [IER_W-1:0] hit;
    iid_e             code;

    assign grp    = group_pending(src);
    assign en_vec = en;

    for (genvar g = 0; g < IER_W; g++) begin : g_gate
        assign hit[g] = grp[g] & en_vec[g];
    end

    always_comb begin
        code = pick_source(src, en);
        iir  = {fifo_en, fifo_en, 2'b00, code};
        irq  = |hit;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CW = 5,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_en,
    input  logic [3:0]    ier,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_trigger,
    input  logic          rx_push,
    input  logic          line_err,
    input  logic          char_timeout,
    input  logic          modem_stat,
    input  logic [CW-1:0] tx_count,
    input  logic          bit_tick,
    input  logic [BW-1:0] char_bits,
    input  logic          iir_rd,
    input  logic          thr_wr,
    input  logic          rbr_rd,
    output logic [7:0]    iir,
    output logic          irq,
    output logic          data_ready
);
    src_t src;
    ier_t en;
    logic rxdata_pend;
    logic timeout_pend;
    logic thre_pend;
    logic thre_ack;
    logic [7:0] iir_w;

    uart_irq_rx_src #(.CW(CW)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .fifo_en      (fifo_en),
        .rx_count     (rx_count),
        .rx_trigger   (rx_trigger),
        .rx_push      (rx_push),
        .rbr_rd       (rbr_rd),
        .char_timeout (char_timeout),
        .rxdata_pend  (rxdata_pend),
        .timeout_pend (timeout_pend),
        .data_ready   (data_ready)
    );

    // a read clears the transmit source only when it is the one reported
    assign thre_ack = iir_rd && (iir_w[3:0] == IID_THRE);

    uart_irq_thre_ctl #(.CW(CW), .BW(BW)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .fifo_en   (fifo_en),
        .tx_count  (tx_count),
        .bit_tick  (bit_tick),
        .char_bits (char_bits),
        .thr_wr    (thr_wr),
        .thre_ack  (thre_ack),
        .thre_pend (thre_pend)
    );

    always_comb begin
        src.modem   = modem_stat;
        src.line    = line_err;
        src.thre    = thre_pend;
        src.timeout = timeout_pend;
        src.rxdata  = rxdata_pend;
        en          = ier;
    end

    uart_irq_prio u_prio (
        .src     (src),
        .en      (en),
        .fifo_en (fifo_en),
        .iir     (iir_w),
        .irq     (irq)
    );

    assign iir = iir_w;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          fifo_en,
    input logic [3:0]    ier,
    input logic [CW-1:0] rx_count,
    input logic          rx_push,
    input logic          line_err,
    input logic          thr_wr,
    input logic [7:0]    iir,
    input logic          irq,
    input logic          data_ready
);
    AST_IRQ_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
        irq == !iir[0]);  // R5
    AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ier == 4'b0000) |-> (iir[3:0] == 4'h1 && !irq));  // R5
    AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
        (ier[2] && line_err) |-> (iir[3:0] == 4'h6));  // R3
    AST_NO_TIMEOUT_PLAIN: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (iir[3:0] != 4'hC));  // R4
    AST_WRITE_CLEARS_THRE: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> (iir[3:0] != 4'h2));  // R6
    AST_DR_SETS: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> data_ready);  // R11
    AST_DR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0 && !rx_push) |=> !data_ready);  // R11
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_en    (fifo_en),
    .ier        (ier),
    .rx_count   (rx_count),
    .rx_push    (rx_push),
    .line_err   (line_err),
    .thr_wr     (thr_wr),
    .iir        (iir),
    .irq        (irq),
    .data_ready (data_ready)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    localparam int CW = 5;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          fifo_en;
    logic [3:0]    ier;
    logic [CW-1:0] rx_count;
    logic [CW-1:0] rx_trigger;
    logic          rx_push;
    logic          line_err;
    logic          char_timeout;
    logic          modem_stat;
    logic [CW-1:0] tx_count;
    logic          bit_tick;
    logic [BW-1:0] char_bits;
    logic          iir_rd;
    logic          thr_wr;
    logic          rbr_rd;
    logic [7:0]    iir;
    logic          irq;
    logic          data_ready;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident #(.CW(CW), .BW(BW)) u_dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .ier(ier),
        .rx_count(rx_count), .rx_trigger(rx_trigger), .rx_push(rx_push),
        .line_err(line_err), .char_timeout(char_timeout), .modem_stat(modem_stat),
        .tx_count(tx_count), .bit_tick(bit_tick), .char_bits(char_bits),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .rbr_rd(rbr_rd),
        .iir(iir), .irq(irq), .data_ready(data_ready)
    );

    // {ier[4], fifo_en, rx_count[5], trigger[5], line, timeout, modem, iir[8], irq}
    localparam int NV = 12;
    localparam logic [26:0] VEC [NV] = '{
        {4'b0001, 1'b1, 5'd4, 5'd8, 1'b0, 1'b0, 1'b0, 8'hC1, 1'b0},  // R2 below trigger
        {4'b0001, 1'b1, 5'd8, 5'd8, 1'b0, 1'b0, 1'b0, 8'hC4, 1'b1},  // R2 at trigger
        {4'b0001, 1'b1, 5'd7, 5'd8, 1'b0, 1'b0, 1'b0, 8'hC1, 1'b0},  // R2 drops below
        {4'b0001, 1'b1, 5'd3, 5'd8, 1'b0, 1'b1, 1'b0, 8'hCC, 1'b1},  // R4 timeout
        {4'b0101, 1'b1, 5'd9, 5'd8, 1'b1, 1'b1, 1'b0, 8'hC6, 1'b1},  // R3 line first
        {4'b0001, 1'b1, 5'd9, 5'd8, 1'b1, 1'b1, 1'b0, 8'hC4, 1'b1},  // R4 data over timeout
        {4'b1001, 1'b1, 5'd0, 5'd8, 1'b0, 1'b0, 1'b1, 8'hC0, 1'b1},  // R3 modem
        {4'b1011, 1'b1, 5'd0, 5'd8, 1'b0, 1'b0, 1'b1, 8'hC2, 1'b1},  // R3 thre over modem
        {4'b0000, 1'b1, 5'd9, 5'd8, 1'b1, 1'b1, 1'b1, 8'hC1, 1'b0},  // R5 polled
        {4'b0001, 1'b0, 5'd1, 5'd8, 1'b0, 1'b0, 1'b0, 8'h04, 1'b1},  // R2 non-FIFO
        {4'b0001, 1'b0, 5'd0, 5'd8, 1'b0, 1'b1, 1'b0, 8'h01, 1'b0},  // R4 timeout ignored
        {4'b0010, 1'b1, 5'd0, 5'd8, 1'b0, 1'b0, 1'b0, 8'hC2, 1'b1}   // R5 thre only
    };

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got hang expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fifo_en = 1'b0; ier = 4'b0000;
        rx_count = '0; rx_trigger = 5'd8; rx_push = 1'b0;
        line_err = 1'b0; char_timeout = 1'b0; modem_stat = 1'b0;
        tx_count = '0; bit_tick = 1'b0; char_bits = 4'd3;
        iir_rd = 1'b0; thr_wr = 1'b0; rbr_rd = 1'b0;
        cyc(); cyc(); cyc();
        chk("R1 reset iir", iir, 8'h01);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        chk("R1 reset dr", {7'd0, data_ready}, 8'h00);

        // R1: reset arms no transmit interrupt
        rst = 1'b0; ier = 4'b0010;
        cyc();
        chk("R1 no thre after reset", iir, 8'h01);

        // R10: FIFO enable change while empty
        fifo_en = 1'b1;
        cyc();
        chk("R10 immediate after fifo change", iir, 8'hC2);

        // R6: read that reports code 2 clears it
        iir_rd = 1'b1; cyc(); iir_rd = 1'b0;
        chk("R6 iir read clears", iir, 8'hC1);

        // R8: single byte drains, delayed by 3 ticks
        tx_count = 5'd1; cyc();
        tx_count = 5'd0; cyc();
        chk("R8 held after empty", iir, 8'hC1);
        bit_tick = 1'b1; cyc(); cyc(); bit_tick = 1'b0;
        chk("R8 held after two ticks", iir, 8'hC1);
        bit_tick = 1'b1; cyc(); bit_tick = 1'b0;
        chk("R8 released on third tick", iir, 8'hC2);

        // R6: holding register write clears
        thr_wr = 1'b1; tx_count = 5'd1; cyc(); thr_wr = 1'b0;
        chk("R6 write clears", iir, 8'hC1);

        // R9: two bytes held at once -> immediate
        tx_count = 5'd2; cyc();
        tx_count = 5'd1; cyc();
        tx_count = 5'd0; cyc();
        chk("R9 immediate after two bytes", iir, 8'hC2);

        // R7: read while line status reported keeps thre
        ier = 4'b0110; line_err = 1'b1; cyc();
        chk("R7 line reported", iir, 8'hC6);
        iir_rd = 1'b1; cyc(); iir_rd = 1'b0;
        line_err = 1'b0; cyc();
        chk("R7 thre survives other read", iir, 8'hC2);

        // R10: change while non-empty arms bypass
        ier = 4'b0010;
        thr_wr = 1'b1; tx_count = 5'd1; cyc(); thr_wr = 1'b0;
        fifo_en = 1'b0; cyc();
        fifo_en = 1'b1; cyc();
        chk("R10 pending cleared before", iir, 8'hC1);
        tx_count = 5'd0; cyc();
        chk("R10 next empty immediate", iir, 8'hC2);

        // R11: data ready
        rx_push = 1'b1; rx_count = 5'd1; cyc(); rx_push = 1'b0;
        chk("R11 dr sets", {7'd0, data_ready}, 8'h01);
        cyc();
        chk("R11 dr holds", {7'd0, data_ready}, 8'h01);
        rbr_rd = 1'b1; cyc(); rbr_rd = 1'b0; rx_count = 5'd0;
        chk("R11 dr clears on last read", {7'd0, data_ready}, 8'h00);
        rx_push = 1'b1; rx_count = 5'd2; cyc(); rx_push = 1'b0;
        rx_count = 5'd0; cyc();
        chk("R11 dr clears when empty", {7'd0, data_ready}, 8'h00);

        // R2 R3 R4 R5 vector table
        for (int i = 0; i < NV; i++) begin
            ier        = VEC[i][26:23];
            fifo_en    = VEC[i][22];
            rx_count   = VEC[i][21:17];
            rx_trigger = VEC[i][16:12];
            line_err   = VEC[i][11];
            char_timeout = VEC[i][10];
            modem_stat = VEC[i][9];
            cyc();
            chk($sformatf("R3 vector %0d iir", i), iir, VEC[i][8:1]);
            chk($sformatf("R5 vector %0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule